// File: doc/BRIEF.md
# Two-wire serial bus slave

This block is the bit-level slave front end of a two-wire, open-drain serial bus. It receives the raw bus clock and data lines and samples them in a faster system clock domain. It finds start and stop conditions and compares the first byte of each transfer with its own device ID. It then either collects written bytes or serialises read bytes. It drives the bus only through an active-low pull-down enable. Off-chip, the bus is pulled up, so the slave only ever pulls the data line low or leaves it released.

A register-access layer sits behind the block and sees only whole bytes. It receives a strobe with each written byte, including the register pointer that follows the address. It receives a pulse when a start or a stop occurs. It receives a request whenever the next read byte is needed. A write of the register pointer may be followed straight away by a repeated start and a read. Reads then continue byte after byte until the master answers with a no-acknowledge.

Top module: `serbus_slave`

## Requirements
- R1: After reset the data line is released (`sda_pull_n` = 1), and `wr_stb`, `rd_req`, `evt_start` and `evt_stop` are 0.
- R2: A falling data line while the clock is high gives a one-cycle `evt_start` pulse. A rising data line while the clock is high gives a one-cycle `evt_stop` pulse.
- R3: The device ID is 0x90 with bit 3 set by `id_sel[0]` and bit 5 set by `id_sel[1]`: `id_sel` 00, 01, 10 and 11 give 0x90, 0x98, 0xB0 and 0xB8. A first byte whose upper seven bits match is acknowledged by pulling data low for the ninth clock.
- R4: A first byte that does not match is not acknowledged. The data line stays released and no `wr_stb` or `rd_req` occurs until the next start.
- R5: In a write transfer, each following byte is received MSB first. It is presented on `wr_byte` with a one-cycle `wr_stb` pulse and acknowledged in its ninth clock.
- R6: The slave changes its drive on the data line only while the bus clock is low.
- R7: In a read transfer, `rd_req` pulses once when the address is acknowledged and once more after each master acknowledge. `rd_data` is taken in the cycle after `rd_req`, and that byte is sent MSB first.
- R8: A master no-acknowledge after a read byte ends the transfer. No further `rd_req` follows, and the data line stays released.
- R9: A repeated start in the middle of a transfer restarts address reception, so a pointer write can be followed directly by a read.
- R10: Bit 0 of the first byte selects the direction: 0 means write and 1 means read. Only read transfers raise `rd_req`, and only write transfers raise `wr_stb`.
- R11: A stop releases the data line and returns the slave to idle from any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line (wired level) |
| id_sel | input | 2 | Strap pins choosing one of four device IDs |
| rd_data | input | 8 | Next read byte, valid the cycle after `rd_req` |
| sda_pull_n | output | 1 | Active-low data pull-down enable |
| evt_start | output | 1 | One-cycle pulse on a start or repeated start |
| evt_stop | output | 1 | One-cycle pulse on a stop |
| wr_stb | output | 1 | One-cycle pulse when a written byte is complete |
| wr_byte | output | 8 | Last written byte, valid with `wr_stb` |
| rd_req | output | 1 | One-cycle request for the next read byte |

## Verification
The assertions assume that each bus clock phase lasts many system clocks, so the synchronised clock is still low in the cycle after the slave acts on a falling edge. They also assume that the master moves the data line with the clock high only to make a start or a stop. The bench keeps to this by holding each clock phase for 20 system cycles and changing its data only while its clock is low, except inside its start and stop tasks. It models the bus as the wired AND of the master's level and the slave's pull-down, and its register-layer model answers each `rd_req` at the next falling system clock edge.

// File: rtl/serbus_pkg.sv
package serbus_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam logic [7:0]  ID_BASE = 8'h90;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WRITE,
        ST_SACK,
        ST_SEND,
        ST_MACK
    } link_state_t;

    // Synchronised line levels and the events found on them
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_evt_t;

    // Strap pin 0 drives ID bit 3, strap pin 1 drives ID bit 5
    function automatic logic [7:0] device_id(input logic [1:0] sel);
        device_id = ID_BASE | {2'b00, sel[1], 1'b0, sel[0], 3'b000};
    endfunction

endpackage

// File: rtl/serbus_sync.sv
module serbus_sync
    import serbus_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_i,
    input  logic      sda_i,
    output line_evt_t ev
);
    logic [1:0] raw, now_s, prev_s;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign now_s[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev_s <= '1;
        else     prev_s <= now_s;
    end

    always_comb begin
        ev.scl      = now_s[0];
        ev.sda      = now_s[1];
        ev.scl_rise = now_s[0] & ~prev_s[0];
        ev.scl_fall = ~now_s[0] & prev_s[0];
        ev.start    = now_s[0] & prev_s[0] & prev_s[1] & ~now_s[1];
        ev.stop     = now_s[0] & prev_s[0] & ~prev_s[1] & now_s[1];
    end

endmodule

// File: rtl/serbus_engine.sv
module serbus_engine
    import serbus_pkg::*;
#(
    parameter int unsigned BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  line_evt_t     ev,
    input  logic [1:0]    id_sel,
    input  logic [BW-1:0] rd_data,
    output logic          pull,
    output logic          evt_start,
    output logic          evt_stop,
    output logic          wr_stb,
    output logic [BW-1:0] wr_byte,
    output logic          rd_req
);
    localparam int unsigned CNT_W = $clog2(BW + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BW);

    link_state_t      state;
    logic [CNT_W-1:0] cnt;
    logic [BW-1:0]    rx, tx;
    logic             rw_q, ack_q, load_q;
    logic [7:0]       my_id;

    assign my_id = device_id(id_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            rx        <= '0;
            tx        <= '0;
            rw_q      <= 1'b0;
            ack_q     <= 1'b0;
            load_q    <= 1'b0;
            pull      <= 1'b0;
            evt_start <= 1'b0;
            evt_stop  <= 1'b0;
            wr_stb    <= 1'b0;
            wr_byte   <= '0;
            rd_req    <= 1'b0;
        end else begin
            evt_start <= 1'b0;
            evt_stop  <= 1'b0;
            wr_stb    <= 1'b0;
            rd_req    <= 1'b0;
            load_q    <= rd_req;
            if (load_q) tx <= rd_data;

            if (ev.stop) begin
                state    <= ST_IDLE;
                pull     <= 1'b0;
                evt_stop <= 1'b1;
            end else if (ev.start) begin
                state     <= ST_ADDR;
                cnt       <= '0;
                pull      <= 1'b0;
                evt_start <= 1'b1;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WRITE: begin
                        if (ev.scl_rise && cnt != FULL) begin
                            rx  <= {rx[BW-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall && cnt == FULL) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (rx[BW-1:1] == my_id[7:1]) begin
                                    pull   <= 1'b1;
                                    rw_q   <= rx[0];
                                    rd_req <= rx[0];
                                    state  <= ST_SACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                pull    <= 1'b1;
                                wr_stb  <= 1'b1;
                                wr_byte <= rx;
                                state   <= ST_SACK;
                            end
                        end
                    end
                    ST_SACK: begin
                        if (ev.scl_fall) begin
                            if (rw_q) begin
                                pull  <= ~tx[BW-1];
                                state <= ST_SEND;
                            end else begin
                                pull  <= 1'b0;
                                state <= ST_WRITE;
                            end
                        end
                    end
                    ST_SEND: begin
                        if (ev.scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (cnt == FULL) begin
                                pull  <= 1'b0;
                                cnt   <= '0;
                                state <= ST_MACK;
                            end else begin
                                tx   <= tx << 1;
                                pull <= ~tx[BW-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (ev.scl_rise) begin
                            ack_q  <= ~ev.sda;
                            rd_req <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (ack_q) begin
                                pull  <= ~tx[BW-1];
                                state <= ST_SEND;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: a stop leaves the data line released on the next cycle
    assert_stop_release_R11: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !pull)
        else $error("pull held after stop");

    // R6: drive changes only with the synchronised clock low, or on a start or stop
    assert_drive_clock_low_R6: assert property (@(posedge clk) disable iff (rst)
        (pull != $past(pull)) |-> (!ev.scl || $past(ev.stop) || $past(ev.start)))
        else $error("data drive changed while clock high");

    // R5: every written byte comes with an acknowledge, in write direction only
    assert_write_acked_R5: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (pull && !rw_q))
        else $error("write strobe without acknowledge");

    // R10: read requests happen only in a read transfer
    assert_read_dir_R10: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> rw_q)
        else $error("read request in write transfer");

    // R4: an idle slave (including after an ID mismatch) never pulls the line
    assert_idle_silent_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !pull)
        else $error("idle slave pulls data line");

endmodule

// File: rtl/serbus_slave.sv
module serbus_slave
    import serbus_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DATA_W      = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        id_sel,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sda_pull_n,
    output logic              evt_start,
    output logic              evt_stop,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_byte,
    output logic              rd_req
);
    line_evt_t ev;
    logic      pull;

    serbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    serbus_engine #(.BW(DATA_W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .id_sel    (id_sel),
        .rd_data   (rd_data),
        .pull      (pull),
        .evt_start (evt_start),
        .evt_stop  (evt_stop),
        .wr_stb    (wr_stb),
        .wr_byte   (wr_byte),
        .rd_req    (rd_req)
    );

    assign sda_pull_n = ~pull;

endmodule

// File: tb/serbus_slave_test.sv
`timescale 1ns/1ps
module serbus_slave_test;

    localparam int H = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] id_sel = 2'b00;
    logic [7:0] rd_data = 8'h00;
    logic       sda_pull_n, evt_start, evt_stop, wr_stb, rd_req;
    logic [7:0] wr_byte;
    logic       sda_line;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int n_start = 0, n_stop = 0, n_wr = 0, n_rdreq = 0, hi_changes = 0;
    logic [7:0] wr_log [0:31];
    logic [7:0] rd_value;
    logic       prev_pull_n = 1'b1;

    always #2 clk = ~clk;

    assign sda_line = m_sda & sda_pull_n;

    serbus_slave uut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .id_sel     (id_sel),
        .rd_data    (rd_data),
        .sda_pull_n (sda_pull_n),
        .evt_start  (evt_start),
        .evt_stop   (evt_stop),
        .wr_stb     (wr_stb),
        .wr_byte    (wr_byte),
        .rd_req     (rd_req)
    );

    // Event monitors and register-layer model
    always @(negedge clk) begin
        if (rst) begin
            rd_value    <= 8'hA5;
            prev_pull_n <= 1'b1;
        end else begin
            prev_pull_n <= sda_pull_n;
            if (m_scl && sda_pull_n != prev_pull_n) hi_changes++;
            if (evt_start) n_start++;
            if (evt_stop)  n_stop++;
            if (wr_stb) begin
                if (n_wr < 32) wr_log[n_wr] = wr_byte;
                n_wr++;
            end
            if (rd_req) begin
                n_rdreq++;
                rd_data  <= rd_value;
                rd_value <= rd_value + 8'h11;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_id(input logic [1:0] sel);
        exp_id = 8'h90 | (sel[0] ? 8'h08 : 8'h00) | (sel[1] ? 8'h20 : 8'h00);
    endfunction

    task automatic bus_start;
        m_sda = 1'b1; hold(H);
        m_scl = 1'b1; hold(H);
        m_sda = 1'b0; hold(H);
        m_scl = 1'b0; hold(H);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; hold(H);
        m_scl = 1'b1; hold(H);
        m_sda = 1'b1; hold(H);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hold(H);
            m_scl = 1'b1; hold(H);
            m_scl = 1'b0;
        end
        m_sda = 1'b1; hold(H);
        m_scl = 1'b1; hold(H / 2);
        acked = !sda_line;
        hold(H / 2);
        m_scl = 1'b0;
    endtask

    task automatic get_byte(output logic [7:0] b, input logic give_ack);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold(H);
            m_scl = 1'b1; hold(H / 2);
            b[i] = sda_line;
            hold(H / 2);
            m_scl = 1'b0;
        end
        m_sda = give_ack ? 1'b0 : 1'b1; hold(H);
        m_scl = 1'b1; hold(H);
        m_scl = 1'b0;
        m_sda = 1'b1;
    endtask

    task automatic t_reset;
        check("R1", "pull_n after reset", 32'(sda_pull_n), 32'd1);
        check("R1", "strobes after reset", 32'({wr_stb, rd_req, evt_start, evt_stop}), 32'd0);
    endtask

    task automatic t_write_burst;
        logic ack;
        int   w0 = n_wr, s0 = n_start, p0 = n_stop, r0 = n_rdreq;
        id_sel = 2'b00;
        bus_start();
        check("R2", "start pulse count", 32'(n_start - s0), 32'd1);
        put_byte(8'h90, ack);
        check("R3", "ack of 0x90 write", 32'(ack), 32'd1);
        put_byte(8'h12, ack);
        check("R5", "ack byte 0x12", 32'(ack), 32'd1);
        put_byte(8'h34, ack);
        check("R5", "ack byte 0x34", 32'(ack), 32'd1);
        put_byte(8'hC3, ack);
        check("R5", "ack byte 0xC3", 32'(ack), 32'd1);
        bus_stop();
        check("R2", "stop pulse count", 32'(n_stop - p0), 32'd1);
        check("R5", "write strobes", 32'(n_wr - w0), 32'd3);
        check("R5", "byte 0", 32'(wr_log[w0]), 32'h12);
        check("R5", "byte 1", 32'(wr_log[w0 + 1]), 32'h34);
        check("R5", "byte 2", 32'(wr_log[w0 + 2]), 32'hC3);
        check("R10", "no read request on write", 32'(n_rdreq - r0), 32'd0);
        check("R11", "released after stop", 32'(sda_pull_n), 32'd1);
    endtask

    task automatic t_id_select;
        logic ack;
        for (int s = 1; s < 4; s++) begin
            int w0 = n_wr;
            id_sel = 2'(s);
            bus_start();
            put_byte(exp_id(2'(s)), ack);
            check("R3", $sformatf("ack id sel=%0d", s), 32'(ack), 32'd1);
            put_byte(8'(s * 8'h21), ack);
            check("R3", $sformatf("data ack sel=%0d", s), 32'(ack), 32'd1);
            bus_stop();
            check("R5", $sformatf("data sel=%0d", s), 32'(wr_log[w0]), 32'(8'(s * 8'h21)));
        end
    endtask

    task automatic t_foreign_id;
        logic ack;
        int   w0 = n_wr, r0 = n_rdreq;
        id_sel = 2'b00;
        bus_start();
        put_byte(8'hB8, ack);
        check("R4", "no ack for 0xB8", 32'(ack), 32'd0);
        put_byte(8'h55, ack);
        check("R4", "no ack for data after mismatch", 32'(ack), 32'd0);
        check("R4", "pull_n after mismatch", 32'(sda_pull_n), 32'd1);
        bus_stop();
        bus_start();
        put_byte(8'h93, ack);
        check("R4", "no ack for 0x93 read", 32'(ack), 32'd0);
        bus_stop();
        check("R4", "no strobes after mismatch", 32'((n_wr - w0) + (n_rdreq - r0)), 32'd0);
    endtask

    task automatic t_read_repeated;
        logic       ack;
        logic [7:0] b;
        int w0 = n_wr, r0 = n_rdreq, s0 = n_start;
        id_sel = 2'b01;
        bus_start();
        put_byte(8'h98, ack);
        check("R3", "ack 0x98", 32'(ack), 32'd1);
        put_byte(8'h05, ack);
        check("R9", "pointer ack", 32'(ack), 32'd1);
        check("R9", "pointer written", 32'(wr_log[w0]), 32'h05);
        bus_start();
        check("R9", "repeated start seen", 32'(n_start - s0), 32'd2);
        put_byte(8'h99, ack);
        check("R9", "read address ack after repeated start", 32'(ack), 32'd1);
        get_byte(b, 1'b1);
        check("R7", "read byte 0", 32'(b), 32'hA5);
        get_byte(b, 1'b1);
        check("R7", "read byte 1", 32'(b), 32'hB6);
        get_byte(b, 1'b0);
        check("R7", "read byte 2", 32'(b), 32'hC7);
        hold(2 * H);
        check("R8", "released after nack", 32'(sda_pull_n), 32'd1);
        check("R8", "requests stop at nack", 32'(n_rdreq - r0), 32'd3);
        check("R10", "no write strobe in read", 32'(n_wr - w0), 32'd1);
        bus_stop();
        check("R6", "drive changes with clock high", 32'(hi_changes), 32'd0);
    endtask

    task automatic t_stop_abort;
        logic ack;
        int   lows = 0;
        int   r0 = n_rdreq, p0 = n_stop, w0 = n_wr;
        id_sel = 2'b01;
        bus_start();
        put_byte(8'h99, ack);
        check("R11", "read address ack", 32'(ack), 32'd1);
        // slave now sends bit 7 of 0xD8 (a 1); master issues a stop mid-byte
        m_sda = 1'b0; hold(H);
        m_scl = 1'b1; hold(H);
        m_sda = 1'b1; hold(H);
        check("R11", "stop pulse mid-read", 32'(n_stop - p0), 32'd1);
        check("R11", "released after stop", 32'(sda_pull_n), 32'd1);
        for (int i = 0; i < 9; i++) begin
            m_scl = 1'b0; hold(H);
            m_scl = 1'b1; hold(H / 2);
            if (!sda_line) lows++;
            hold(H / 2);
        end
        check("R11", "line quiet after stop", 32'(lows), 32'd0);
        check("R11", "only address request", 32'(n_rdreq - r0), 32'd1);
        bus_start();
        put_byte(8'h98, ack);
        check("R11", "recovery address ack", 32'(ack), 32'd1);
        put_byte(8'h77, ack);
        bus_stop();
        check("R11", "recovery write", 32'(wr_log[w0]), 32'h77);
    endtask

    initial begin
        hold(6);
        rst = 1'b0;
        hold(2);
        t_reset();
        t_write_burst();
        t_id_select();
        t_foreign_id();
        t_read_repeated();
        t_stop_abort();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule